// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits next to a DRAM access controller and takes charge of two jobs the controller would rather not carry: bringing the device up after power is applied, and keeping every row refreshed while traffic runs. After reset it stays silent for the power-up pause. It then runs a fixed number of initialisation cycles, every one of them a refresh, and afterwards signals that the controller may start normal accesses.

In operation an interval timer marks one owed refresh per row slot. The slot length is the refresh period divided by the row count, and the period is chosen by the row-address width. Owed refreshes collect in a saturating debt counter. While any are owed, the block raises a request to the controller. It drives the strobes only after the grant is seen, then issues the whole debt as a burst.

Each refresh is of one of two kinds, picked by a mode input when the cycle starts. In CAS-before-RAS mode the device's own counter supplies the row. In RAS-only mode the block drives a row address from its own wrapping counter and keeps CAS high. Write-enable is held high throughout, so a CAS-before-RAS cycle can never be read as test-mode entry.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low and right after it rises: refresh_req_o=0, ras_n_o=1, cas_n_o=1, addr_oe_o=0, we_n_o=1, init_done_o=0.
- R2: refresh_req_o stays low for PAUSE_CYC = CLK_KHZ*PAUSE_US/1000 clock cycles after reset. It first rises in cycle PAUSE_CYC, counting the first edge after reset release as cycle 1.
- R3: Exactly INIT_CYCLES refresh cycles (falling edges of ras_n_o) happen before init_done_o rises. init_done_o rises at the end of the last one's precharge and never falls until reset.
- R4: ras_n_o low, cas_n_o low or addr_oe_o high occur only while refresh_req_o is high. A cycle starts only after refresh_gnt_i is sampled high in the idle state.
- R5: In CAS-before-RAS mode (mode_ror_i=0) addr_oe_o stays 0 and cas_n_o falls T_SU cycles before ras_n_o falls. cas_n_o stays low for as long as ras_n_o is low. we_n_o is 1 at all times.
- R6: When another CAS-before-RAS refresh is owed at the end of a cycle's low-RAS phase, cas_n_o stays low through precharge and idle, and the next cycle pulls ras_n_o low with no new setup phase.
- R7: In RAS-only mode (mode_ror_i=1) cas_n_o stays 1 and addr_oe_o is 1 from setup through precharge. addr_o carries the internal row counter, which starts at 0 and advances by one modulo 2**ROW_BITS after each RAS-only cycle.
- R8: After init_done_o, one refresh is owed every INTERVAL = CLK_KHZ*PERIOD_MS/2**ROW_BITS cycles, with PERIOD_MS = 64 for ROW_BITS >= 12 and 32 otherwise. With no backlog, successive rises of refresh_req_o are exactly INTERVAL cycles apart.
- R9: Up to MAX_POSTPONE owed refreshes are kept while the grant is withheld, and further ones are dropped. On grant, every kept refresh is issued back to back.
- R10: ras_n_o is low for exactly T_RAS cycles in every refresh cycle, followed by T_RP precharge cycles. refresh_req_o falls in the cycle after the last owed cycle's precharge.
- R11: If a new refresh falls due in the same cycle that an owed one completes, the owed count stays unchanged and one more cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_ror_i | input | 1 | 0: CAS-before-RAS refresh, 1: RAS-only refresh; sampled at each cycle start |
| refresh_gnt_i | input | 1 | Controller hands the strobe bus to this block |
| refresh_req_o | output | 1 | Request for the strobe bus |
| init_done_o | output | 1 | Power-up sequence complete; normal traffic allowed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |
| addr_oe_o | output | 1 | Block drives the row address |
| addr_o | output | ROW_BITS | Row address for RAS-only refresh |

## Verification
The interval timer can fall due in the same clock edge in which the last owed refresh finishes its precharge. The owed count then has to absorb an increment and a decrement at once. The bench provokes this by withholding the grant until exactly one refresh is owed, then releasing it at a sweep of offsets before the next due point, so that completion and the new due mark land together for at least one offset. The behavioural model predicts the extra back-to-back cycle, the strobes are compared every clock, and the bench requires that the coincidence was actually reached.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_SETUP,
    ST_ACT,
    ST_PRE
  } rfsh_state_e;

  function automatic int unsigned period_ms(input int unsigned row_bits);
    return (row_bits >= 12) ? 64 : 32;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/refresh_tick_gen.sv
module refresh_tick_gen #(
  parameter int unsigned INTERVAL = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned IW = $clog2(INTERVAL + 1);

  logic [IW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == IW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + IW'(1);
  end
endmodule

// File: rtl/refresh_debt.sv
module refresh_debt #(
  parameter int unsigned MAX_POSTPONE = 8,
  localparam int unsigned DW = $clog2(MAX_POSTPONE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  output logic [DW-1:0] debt_o
);
  logic [DW-1:0] debt_q;

  assign debt_o = debt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      debt_q <= '0;
    end else if (inc_i && !dec_i) begin
      if (debt_q != DW'(MAX_POSTPONE)) debt_q <= debt_q + DW'(1);
    end else if (dec_i && !inc_i) begin
      debt_q <= debt_q - DW'(1);
    end
  end
endmodule

// File: rtl/refresh_strobe_fsm.sv
module refresh_strobe_fsm
  import dram_refresh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 20000,
  parameter int unsigned INIT_CYCLES = 8,
  parameter int unsigned ROW_BITS    = 12,
  parameter int unsigned DEBT_W      = 4,
  parameter int unsigned T_SU        = 2,
  parameter int unsigned T_RAS       = 5,
  parameter int unsigned T_RP        = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_ror_i,
  input  logic                gnt_i,
  input  logic [DEBT_W-1:0]   debt_i,
  output logic                init_done_o,
  output logic                cycle_done_o,
  output logic                req_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                addr_oe_o,
  output logic [ROW_BITS-1:0] addr_o
);
  localparam int unsigned CMAX = max2(max2(PAUSE_CYC, T_SU), max2(T_RAS, T_RP));
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned NW   = $clog2(INIT_CYCLES + 1);

  rfsh_state_e         state_q;
  logic [CW-1:0]       cnt_q;
  logic [NW-1:0]       init_q;
  logic [ROW_BITS-1:0] row_q;
  logic                ror_q, burst_q, hold_q;
  logic                need, more, phase_end, last, busy;

  assign need        = (init_q != '0) || (debt_i != '0);
  assign more        = (init_q > NW'(1)) || ((init_q == '0) && (debt_i > DEBT_W'(1)));
  assign phase_end   = (cnt_q == '0);
  assign last        = (state_q == ST_PRE) && phase_end;
  assign busy        = (state_q == ST_SETUP) || (state_q == ST_ACT) || (state_q == ST_PRE);
  assign init_done_o = (init_q == '0);
  assign cycle_done_o = last && (init_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      cnt_q   <= CW'(PAUSE_CYC - 1);
      init_q  <= NW'(INIT_CYCLES);
      row_q   <= '0;
      ror_q   <= 1'b0;
      burst_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_PAUSE: begin
          if (phase_end) state_q <= ST_IDLE;
          else           cnt_q   <= cnt_q - CW'(1);
        end
        ST_IDLE: begin
          if (need && gnt_i) begin
            hold_q <= 1'b0;
            if (hold_q && !mode_ror_i) begin
              // CAS already low from previous cycle: go straight to RAS low
              state_q <= ST_ACT;
              cnt_q   <= CW'(T_RAS - 1);
              ror_q   <= 1'b0;
            end else begin
              state_q <= ST_SETUP;
              cnt_q   <= CW'(T_SU - 1);
              ror_q   <= mode_ror_i;
            end
          end
        end
        ST_SETUP: begin
          if (phase_end) begin
            state_q <= ST_ACT;
            cnt_q   <= CW'(T_RAS - 1);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_ACT: begin
          if (phase_end) begin
            state_q <= ST_PRE;
            cnt_q   <= CW'(T_RP - 1);
            burst_q <= !ror_q && more;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_PRE: begin
          if (phase_end) begin
            state_q <= ST_IDLE;
            hold_q  <= burst_q;
            burst_q <= 1'b0;
            if (init_q != '0) init_q <= init_q - NW'(1);
            if (ror_q)        row_q  <= row_q + ROW_BITS'(1);
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_o     = busy || ((state_q == ST_IDLE) && (need || hold_q));
    ras_n_o   = (state_q != ST_ACT);
    addr_oe_o = ror_q && busy;
    addr_o    = row_q;
    unique case (state_q)
      ST_IDLE:           cas_n_o = !hold_q;
      ST_SETUP, ST_ACT:  cas_n_o = ror_q;
      ST_PRE:            cas_n_o = ror_q || !burst_q;
      default:           cas_n_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_refresh_pkg::*;
#(
  parameter int unsigned CLK_KHZ      = 100000,
  parameter int unsigned PAUSE_US     = 200,
  parameter int unsigned ROW_BITS     = 12,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned MAX_POSTPONE = 8,
  parameter int unsigned T_SU         = 2,
  parameter int unsigned T_RAS        = 5,
  parameter int unsigned T_RP         = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mode_ror_i,
  input  logic                refresh_gnt_i,
  output logic                refresh_req_o,
  output logic                init_done_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic                addr_oe_o,
  output logic [ROW_BITS-1:0] addr_o
);
  localparam int unsigned ROWS      = 2 ** ROW_BITS;
  localparam int unsigned PERIOD_MS = period_ms(ROW_BITS);
  localparam int unsigned INTERVAL  = CLK_KHZ * PERIOD_MS / ROWS;
  localparam int unsigned PAUSE_CYC = CLK_KHZ * PAUSE_US / 1000;
  localparam int unsigned DEBT_W    = $clog2(MAX_POSTPONE + 1);

  logic              tick, cyc_done;
  logic [DEBT_W-1:0] debt;

  refresh_tick_gen #(.INTERVAL(INTERVAL)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (init_done_o),
    .tick_o (tick)
  );

  refresh_debt #(.MAX_POSTPONE(MAX_POSTPONE)) u_debt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (tick),
    .dec_i  (cyc_done),
    .debt_o (debt)
  );

  refresh_strobe_fsm #(
    .PAUSE_CYC   (PAUSE_CYC),
    .INIT_CYCLES (INIT_CYCLES),
    .ROW_BITS    (ROW_BITS),
    .DEBT_W      (DEBT_W),
    .T_SU        (T_SU),
    .T_RAS       (T_RAS),
    .T_RP        (T_RP)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_ror_i   (mode_ror_i),
    .gnt_i        (refresh_gnt_i),
    .debt_i       (debt),
    .init_done_o  (init_done_o),
    .cycle_done_o (cyc_done),
    .req_o        (refresh_req_o),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o),
    .addr_oe_o    (addr_oe_o),
    .addr_o       (addr_o)
  );

  assign we_n_o = 1'b1;
endmodule

// File: rtl/dram_refresh_seq_chk.sv
module dram_refresh_seq_chk #(
  parameter int unsigned ROW_BITS  = 12,
  parameter int unsigned PAUSE_CYC = 20000,
  parameter int unsigned T_RAS     = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                refresh_req_o,
  input logic                init_done_o,
  input logic                ras_n_o,
  input logic                cas_n_o,
  input logic                addr_oe_o,
  input logic [ROW_BITS-1:0] addr_o
);
  int unsigned since_rst;
  int unsigned ras_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= 0;
      ras_lo    <= 0;
    end else begin
      if (since_rst < PAUSE_CYC) since_rst <= since_rst + 1;
      ras_lo <= ras_n_o ? 0 : ras_lo + 1;
    end
  end

  assert_pause_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < PAUSE_CYC) |-> !refresh_req_o);

  assert_done_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);

  assert_strobe_owned_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o || addr_oe_o) |-> refresh_req_o);

  assert_cas_under_ras_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && !addr_oe_o) |-> !cas_n_o);

  assert_cas_leads_ras_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && !addr_oe_o) |-> !$past(cas_n_o));

  assert_ror_cas_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_oe_o |-> cas_n_o);

  assert_row_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(addr_oe_o) |-> (addr_o == ROW_BITS'($past(addr_o) + 1'b1)));

  assert_ras_width_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (ras_lo == T_RAS));
endmodule

bind dram_refresh_seq dram_refresh_seq_chk #(
  .ROW_BITS  (ROW_BITS),
  .PAUSE_CYC (PAUSE_CYC),
  .T_RAS     (T_RAS)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .refresh_req_o (refresh_req_o),
  .init_done_o   (init_done_o),
  .ras_n_o       (ras_n_o),
  .cas_n_o       (cas_n_o),
  .addr_oe_o     (addr_oe_o),
  .addr_o        (addr_o)
);

// File: tb/dram_refresh_seq_test.sv
module dram_refresh_seq_test;
  localparam int ROW_BITS  = 12;
  localparam int INIT_CYC  = 8;
  localparam int MAXP      = 8;
  localparam int T_SU      = 2;
  localparam int T_RAS     = 5;
  localparam int T_RP      = 4;
  localparam int PAUSE_CYC = 100000 * 200 / 1000;
  localparam int INTERVAL  = 100000 * 64 / 4096;
  localparam int ROWS      = 1 << ROW_BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic gnt = 1'b0;
  logic req, done, ras_n, cas_n, we_n, aoe;
  logic [ROW_BITS-1:0] addr;

  always #5 clk = ~clk;

  dram_refresh_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_ror_i(mode), .refresh_gnt_i(gnt),
    .refresh_req_o(req), .init_done_o(done), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .addr_oe_o(aoe), .addr_o(addr)
  );

  int checks = 0;
  int errors = 0;
  bit auto_gnt = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: stage 0 pause,1 idle,2 setup,3 ras low,4 precharge
  int m_stage, m_left, m_init, m_debt, m_row, m_icnt, m_ticks, m_coinc;
  bit m_ror, m_burst, m_hold;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stage = 0; m_left = PAUSE_CYC - 1; m_init = INIT_CYC; m_debt = 0;
      m_row = 0; m_icnt = 0; m_ror = 0; m_burst = 0; m_hold = 0;
      m_ticks = 0; m_coinc = 0;
    end else begin
      bit tk, fin, dn, need, more;
      int n_debt, n_icnt;
      tk   = (m_init == 0) && (m_icnt == INTERVAL - 1);
      fin  = (m_stage == 4) && (m_left == 0);
      dn   = fin && (m_init == 0);
      need = (m_init != 0) || (m_debt != 0);
      more = (m_init > 1) || (m_init == 0 && m_debt > 1);
      if (tk) m_ticks++;
      if (tk && dn) m_coinc++;
      n_debt = m_debt;
      if (tk && !dn) begin if (m_debt < MAXP) n_debt = m_debt + 1; end
      else if (dn && !tk) n_debt = m_debt - 1;
      n_icnt = (m_init != 0 || tk) ? 0 : m_icnt + 1;
      case (m_stage)
        0: if (m_left == 0) m_stage = 1; else m_left--;
        1: if (need && gnt) begin
             if (m_hold && !mode) begin m_stage = 3; m_left = T_RAS - 1; m_ror = 0; end
             else begin m_stage = 2; m_left = T_SU - 1; m_ror = mode; end
             m_hold = 0;
           end
        2: if (m_left == 0) begin m_stage = 3; m_left = T_RAS - 1; end else m_left--;
        3: if (m_left == 0) begin m_stage = 4; m_left = T_RP - 1; m_burst = !m_ror && more; end
           else m_left--;
        default: if (m_left == 0) begin
             m_stage = 1; m_hold = m_burst; m_burst = 0;
             if (m_init != 0) m_init--;
             if (m_ror) m_row = (m_row + 1) % ROWS;
           end else m_left--;
      endcase
      m_debt = n_debt;
      m_icnt = n_icnt;
    end
  end

  function automatic bit e_req();
    return (m_stage >= 2) || (m_stage == 1 && (m_init != 0 || m_debt != 0 || m_hold));
  endfunction
  function automatic bit e_cas_n();
    case (m_stage)
      1: return !m_hold;
      2, 3: return m_ror;
      4: return m_ror || !m_burst;
      default: return 1'b1;
    endcase
  endfunction

  // per-cycle compare, monitor and grant driver
  int cyc = 0, ras_falls = 0, cas_rises = 0, req_rises = 0, last_rise = 0, prev_rise = 0;
  int ror_seen = 0;
  bit p_ras = 1, p_cas = 1, p_req = 0, p_aoe = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(req == e_req(), "R4 req", req, e_req());
      chk(ras_n == (m_stage != 3), "R10 ras_n", ras_n, m_stage != 3);
      chk(cas_n == e_cas_n(), "R5/R6 cas_n", cas_n, e_cas_n());
      chk(we_n == 1'b1, "R5 we_n", we_n, 1);
      chk(aoe == (m_ror && m_stage >= 2), "R7 addr_oe", aoe, m_ror && m_stage >= 2);
      chk(done == (m_init == 0), "R3 init_done", done, m_init == 0);
      if (aoe) chk(addr == m_row[ROW_BITS-1:0], "R7 addr", addr, m_row);
      if (p_ras && !ras_n) ras_falls++;
      if (!p_cas && cas_n) cas_rises++;
      if (!p_req && req) begin prev_rise = last_rise; last_rise = cyc; req_rises++; end
      if (!p_aoe && aoe) begin
        chk(int'(addr) == ror_seen % ROWS, "R7 row sequence", addr, ror_seen % ROWS);
        ror_seen++;
      end
      p_ras = ras_n; p_cas = cas_n; p_req = req; p_aoe = aoe;
      gnt = auto_gnt && req;
    end
  end

  task automatic wait_req_low();
    do @(negedge clk); while (!req);
    do @(negedge clk); while (req);
  endtask

  task automatic wait_ticks(input int n);
    int t0 = m_ticks;
    do @(negedge clk); while (m_ticks < t0 + n);
  endtask

  initial begin
    int n, f0, c0, r0;
    repeat (3) @(negedge clk);
    chk(!req && ras_n && cas_n && !aoe && we_n && !done, "R1 reset outputs", {req, ras_n, cas_n, aoe, done}, 5'b01100);
    rst_n = 1'b1;
    chk(!req && ras_n && cas_n && !done, "R1 after release", {req, ras_n, cas_n, done}, 4'b0110);

    n = 0;
    do begin @(negedge clk); n++; end while (!req);
    chk(n == PAUSE_CYC, "R2 first request cycle", n, PAUSE_CYC);

    do @(negedge clk); while (!done);
    chk(ras_falls == INIT_CYC, "R3 init refresh count", ras_falls, INIT_CYC);
    chk(cas_rises == 1, "R6 init burst keeps CAS low", cas_rises, 1);

    r0 = req_rises;
    do @(negedge clk); while (req_rises < r0 + 2);
    chk(last_rise - prev_rise == INTERVAL, "R8 request spacing", last_rise - prev_rise, INTERVAL);

    wait_req_low();
    auto_gnt = 1'b0;
    wait_ticks(3);
    f0 = ras_falls; c0 = cas_rises;
    auto_gnt = 1'b1;
    wait_req_low();
    chk(ras_falls - f0 == 3, "R9 postponed burst length", ras_falls - f0, 3);
    chk(cas_rises - c0 == 1, "R6 CAS held across burst", cas_rises - c0, 1);

    auto_gnt = 1'b0;
    wait_ticks(MAXP + 3);
    f0 = ras_falls;
    auto_gnt = 1'b1;
    wait_req_low();
    chk(ras_falls - f0 == MAXP, "R9 saturated backlog", ras_falls - f0, MAXP);

    for (int k = 0; k < 12; k++) begin
      auto_gnt = 1'b0;
      wait_ticks(1);
      repeat (INTERVAL - (k + 8)) @(negedge clk);
      auto_gnt = 1'b1;
      do @(negedge clk); while (req);
    end
    chk(m_coinc >= 1, "R11 due and completion coincided", m_coinc, 1);

    mode = 1'b1;
    wait_ticks(2);
    wait_req_low();
    auto_gnt = 1'b0;
    wait_ticks(3);
    f0 = ras_falls;
    auto_gnt = 1'b1;
    wait_req_low();
    chk(ras_falls - f0 == 3, "R7 RAS-only burst length", ras_falls - f0, 3);
    chk(ror_seen == 5, "R7 RAS-only cycles seen", ror_seen, 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule